// File: doc/BRIEF.md
# Two-Cache Snooping Line Coherence Controller

This block keeps one memory word coherent between two private caches that sit on a shared snooping bus. Each cache holds the word in one of three conditions: absent, a clean copy that others may also hold, or a sole dirty copy. A processor read that finds no copy puts a fetch on the bus. A processor write that finds no sole copy puts a kill (invalidate) on the bus, which removes the other cache's copy. A fetch that meets a dirty copy in the other cache is served by that cache rather than memory; the value is written back at the same time and both end up clean.

The two caches contend for the bus through a fixed-priority arbiter that passes one transaction per cycle, with cache 0 ahead. Each processor port raises a request and holds it until a one-cycle acknowledge returns; read data is valid with the acknowledge. A cache keeps snooping while its own request waits, so a request may be served from a different line condition than the one it saw when it arrived.

Top module: `snoop_coh_pair`

## Requirements
- R1: While reset is held, and after it is released with no request, both line states read 0 (absent), both acknowledges are 0 and the memory word is 0. The line state encoding is 0 absent, 1 clean shared, 2 dirty sole owner.
- R2: A read in a cache whose state is 0, while the other cache is not in state 2, returns the memory word and leaves the reader in state 1.
- R3: A write in a cache whose state is 0 or 1 takes the bus, drives the other cache to state 0, leaves the writer in state 2 holding the written value, and leaves the memory word unchanged.
- R4: A write in a cache already in state 2 completes without taking the bus and stores the new value.
- R5: A read in a cache in state 0 while the other cache is in state 2 returns the other cache's value, copies that value into the memory word, and leaves both caches in state 1.
- R6: A read in a cache in state 1 or 2 returns the cache's own copy without taking the bus and leaves both states unchanged.
- R7: At no time is one cache in state 2 while the other is in state 1 or 2.
- R8: At most one bus transaction is granted per cycle; when both caches need the bus in the same cycle cache 0 is served first and cache 1 one cycle later.
- R9: A request that hits locally is held back during any cycle in which the other cache owns the bus, and is then served one cycle later against the line state that the snooped transaction left.
- R10: A request is acknowledged by a single-cycle pulse on the clock edge on which it is served; an unobstructed request is served on the first edge at which it is seen.
- R11: Every read returns the value of the most recent write to the word by either cache, in the order the bus serialized them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 2 | Per-cache request, held until acknowledged |
| cpu_wr | input | 2 | Per-cache write (1) or read (0) |
| cpu_wdata | input | 2 x DW | Per-cache write value |
| cpu_ack | output | 2 | Per-cache one-cycle completion pulse |
| cpu_rdata | output | 2 x DW | Per-cache read value, valid with acknowledge |
| line_state | output | 2 x 2 | Per-cache line state (0 absent, 1 shared, 2 owned dirty) |
| mem_data | output | DW | Current memory copy of the word |

## Verification
The collision that matters is one cache's local hit landing in the same cycle as the other cache's bus transaction, which snoops and may change the line under the hit. The bench provokes it by raising both requests together for every pairing of idle, read and write across a drifting sequence of line states, so hits meet fetches and kills from every starting condition. Each acknowledge is judged by the edge it arrives on (first or second) and by its data, compared with a sequential model that serves the bus user first and the deferred hit afterwards.

// File: rtl/snoopc_pkg.sv
package snoopc_pkg;
  localparam int NCACHE = 2;

  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_MOD = 2'd2
  } line_st_e;

  typedef enum logic {
    OP_FETCH = 1'b0,
    OP_KILL  = 1'b1
  } bus_op_e;
endpackage

// File: rtl/snoopc_arb.sv
module snoopc_arb #(
  parameter int NREQ = 2
) (
  input  logic [NREQ-1:0] need,
  output logic [NREQ-1:0] gnt
);
  // lower index always wins
  for (genvar k = 0; k < NREQ; k++) begin : g_pri
    if (k == 0) begin : g_top
      assign gnt[k] = need[k];
    end else begin : g_rest
      assign gnt[k] = need[k] & ~(|need[k-1:0]);
    end
  end
endmodule

// File: rtl/snoopc_line.sv
module snoopc_line
  import snoopc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          gnt,
  input  logic          snoop_vld,
  input  bus_op_e       snoop_op,
  input  logic [DW-1:0] fill_data,
  output logic          need_bus,
  output bus_op_e       bus_op,
  output line_st_e      st_o,
  output logic [DW-1:0] line_o,
  output logic          ack,
  output logic [DW-1:0] rdata
);
  line_st_e      st_q, st_n;
  logic [DW-1:0] line_q, line_n, rdata_q, rdata_n;
  logic          ack_q, ack_n;
  logic          line_en, rdata_en;
  logic          live, hit, serve;

  always_comb begin
    live     = req & ~ack_q;
    hit      = wr ? (st_q == LN_MOD) : (st_q != LN_INV);
    need_bus = live & ~hit;
    bus_op   = wr ? OP_KILL : OP_FETCH;
    serve    = live & (hit ? ~snoop_vld : gnt);

    st_n     = st_q;
    line_n   = line_q;
    rdata_n  = rdata_q;
    line_en  = 1'b0;
    rdata_en = 1'b0;
    ack_n    = serve;

    if (snoop_vld) begin
      if (snoop_op == OP_KILL)  st_n = LN_INV;
      else if (st_q == LN_MOD)  st_n = LN_SHR;
    end

    if (serve) begin
      if (wr) begin
        st_n    = LN_MOD;
        line_n  = wdata;
        line_en = 1'b1;
      end else if (hit) begin
        rdata_n  = line_q;
        rdata_en = 1'b1;
      end else begin
        st_n     = LN_SHR;
        line_n   = fill_data;
        line_en  = 1'b1;
        rdata_n  = fill_data;
        rdata_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LN_INV;
      ack_q   <= 1'b0;
      line_q  <= '0;
      rdata_q <= '0;
    end else begin
      st_q  <= st_n;
      ack_q <= ack_n;
      if (line_en)  line_q  <= line_n;
      if (rdata_en) rdata_q <= rdata_n;
    end
  end

  assign st_o   = st_q;
  assign line_o = line_q;
  assign ack    = ack_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/snoop_coh_pair.sv
module snoop_coh_pair
  import snoopc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCACHE-1:0]        cpu_req,
  input  logic [NCACHE-1:0]        cpu_wr,
  input  logic [NCACHE-1:0][DW-1:0] cpu_wdata,
  output logic [NCACHE-1:0]        cpu_ack,
  output logic [NCACHE-1:0][DW-1:0] cpu_rdata,
  output logic [NCACHE-1:0][1:0]   line_state,
  output logic [DW-1:0]            mem_data
);
  logic [1:0]      rst_sync;
  logic            rst_i_n;
  logic [NCACHE-1:0] need, gnt;
  bus_op_e         bop  [NCACHE];
  line_st_e        lst  [NCACHE];
  logic [DW-1:0]   lval [NCACHE];
  logic [DW-1:0]   fill [NCACHE];
  logic [DW-1:0]   mem_q, mem_n;
  logic            mem_en;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  snoopc_arb #(.NREQ(NCACHE)) u_arb (.need(need), .gnt(gnt));

  for (genvar i = 0; i < NCACHE; i++) begin : g_cache
    localparam int PEER = NCACHE - 1 - i;
    assign fill[i] = (lst[PEER] == LN_MOD) ? lval[PEER] : mem_q;

    snoopc_line #(.DW(DW)) u_line (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .req       (cpu_req[i]),
      .wr        (cpu_wr[i]),
      .wdata     (cpu_wdata[i]),
      .gnt       (gnt[i]),
      .snoop_vld (gnt[PEER]),
      .snoop_op  (bop[PEER]),
      .fill_data (fill[i]),
      .need_bus  (need[i]),
      .bus_op    (bop[i]),
      .st_o      (lst[i]),
      .line_o    (lval[i]),
      .ack       (cpu_ack[i]),
      .rdata     (cpu_rdata[i])
    );
    assign line_state[i] = lst[i];
  end

  // owner write-back on a peer fetch
  always_comb begin
    mem_n  = mem_q;
    mem_en = 1'b0;
    for (int i = 0; i < NCACHE; i++) begin
      if (gnt[i] && bop[i] == OP_FETCH && lst[NCACHE-1-i] == LN_MOD) begin
        mem_n  = lval[NCACHE-1-i];
        mem_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    mem_q <= '0;
    else if (mem_en) mem_q <= mem_n;
  end

  assign mem_data = mem_q;
endmodule

// File: rtl/snoopc_chk.sv
module snoopc_chk
  import snoopc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCACHE-1:0]         cpu_req,
  input logic [NCACHE-1:0]         cpu_wr,
  input logic [NCACHE-1:0]         cpu_ack,
  input logic [NCACHE-1:0][DW-1:0] cpu_rdata,
  input logic [NCACHE-1:0][1:0]    line_state,
  input logic [DW-1:0]             mem_data,
  input logic [NCACHE-1:0]         gnt
);
  // R7
  single_owner0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_state[0] == LN_MOD |-> line_state[1] == LN_INV);
  // R7
  single_owner1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_state[1] == LN_MOD |-> line_state[0] == LN_INV);
  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  // R3
  kill_peer0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] && cpu_wr[0] |=> line_state[1] == LN_INV && line_state[0] == LN_MOD);
  // R3
  kill_peer1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[1] && cpu_wr[1] |=> line_state[0] == LN_INV && line_state[1] == LN_MOD);
  // R4
  owned_write_nobus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req[0] && cpu_wr[0] && line_state[0] == LN_MOD |-> !gnt[0]);
  // R5
  owner_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] && !cpu_wr[0] && line_state[1] == LN_MOD
      |=> line_state[1] == LN_SHR && cpu_rdata[0] == mem_data);
  // R10
  ack_pulse0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack[0] |=> !cpu_ack[0]);
  // R10
  ack_pulse1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack[1] |=> !cpu_ack[1]);
endmodule

bind snoop_coh_pair snoopc_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .cpu_req    (cpu_req),
  .cpu_wr     (cpu_wr),
  .cpu_ack    (cpu_ack),
  .cpu_rdata  (cpu_rdata),
  .line_state (line_state),
  .mem_data   (mem_data),
  .gnt        (gnt)
);

// File: tb/tb_snoop_coh_pair.sv
module tb_snoop_coh_pair;
  localparam int DW = 8;

  logic                 clk;
  logic                 rst_n;
  logic [1:0]           cpu_req;
  logic [1:0]           cpu_wr;
  logic [1:0][DW-1:0]   cpu_wdata;
  logic [1:0]           cpu_ack;
  logic [1:0][DW-1:0]   cpu_rdata;
  logic [1:0][1:0]      line_state;
  logic [DW-1:0]        mem_data;

  int total = 0;
  int bad   = 0;

  // model: 0 absent, 1 shared, 2 owned
  int          mst  [2];
  logic [DW-1:0] mline[2];
  logic [DW-1:0] mmem;

  snoop_coh_pair #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .line_state(line_state), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit needs(int i, int op);
    if (op == 1) return mst[i] == 0;
    if (op == 2) return mst[i] != 2;
    return 1'b0;
  endfunction

  // applies one served op to the model, returns its requirement tag
  function automatic string apply(int i, int op, logic [DW-1:0] v);
    int o = 1 - i;
    string t;
    if (op == 1) begin
      if (mst[i] == 0) begin
        if (mst[o] == 2) begin
          t = "R5"; mmem = mline[o]; mst[o] = 1;
        end else t = "R2";
        mline[i] = mmem; mst[i] = 1;
      end else t = "R6";
    end else begin
      if (mst[i] == 2) t = "R4";
      else begin t = "R3"; mst[o] = 0; end
      mst[i] = 2; mline[i] = v;
    end
    return t;
  endfunction

  task automatic run_pair(int op0, int op1, logic [DW-1:0] v0, logic [DW-1:0] v1);
    int ops[2];
    int order[2];
    int expc[2];
    logic [DW-1:0] exprd[2];
    string tg[2];
    bit got[2];
    bit n0, n1, c1first;
    ops[0] = op0; ops[1] = op1;
    n0 = needs(0, op0); n1 = needs(1, op1);
    c1first = n1 && !n0;
    order[0] = c1first ? 1 : 0;
    order[1] = c1first ? 0 : 1;
    for (int k = 0; k < 2; k++) begin
      int i = order[k];
      expc[i] = 0; got[i] = 1'b1; tg[i] = "";
      if (ops[i] != 0) begin
        got[i] = 1'b0;
        tg[i] = apply(i, ops[i], (i == 0) ? v0 : v1);
        exprd[i] = mline[i];
        if (k == 0 || (!n0 && !n1)) expc[i] = 1;
        else expc[i] = 2;
      end
    end
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      cpu_req[i]   = (ops[i] != 0);
      cpu_wr[i]    = (ops[i] == 2);
      cpu_wdata[i] = (i == 0) ? v0 : v1;
    end
    for (int n = 1; n <= 4; n++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        if (cpu_req[i] && cpu_ack[i]) begin
          if (expc[i] == 1 && (ops[1-i] == 0 || (!n0 && !n1) || i == order[0]))
            check("R10", $sformatf("ack edge c%0d", i), n, expc[i]);
          else if ((i == 0 && !n0) || (i == 1 && !n1))
            check("R9", $sformatf("deferred hit edge c%0d", i), n, expc[i]);
          else
            check("R8", $sformatf("second bus user edge c%0d", i), n, expc[i]);
          if (ops[i] == 1)
            check($sformatf("%s,R11", tg[i]), $sformatf("rdata c%0d", i),
                  int'(cpu_rdata[i]), int'(exprd[i]));
          cpu_req[i] = 1'b0;
          got[i] = 1'b1;
        end
      end
    end
    for (int i = 0; i < 2; i++) begin
      if (!got[i]) check("R10", $sformatf("missing ack c%0d", i), 0, 1);
      check("R10", $sformatf("ack idle c%0d", i), int'(cpu_ack[i]), 0);
      check(tg[i] == "" ? "R7" : tg[i], $sformatf("state c%0d", i),
            int'(line_state[i]), mst[i]);
    end
    check("R5", "memory word", int'(mem_data), int'(mmem));
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = '0; cpu_wr = '0; cpu_wdata = '0;
    mst[0] = 0; mst[1] = 0; mline[0] = '0; mline[1] = '0; mmem = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "ack during reset", int'(cpu_ack), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check("R1", "state c0", int'(line_state[0]), 0);
    check("R1", "state c1", int'(line_state[1]), 0);
    check("R1", "ack", int'(cpu_ack), 0);
    check("R1", "memory", int'(mem_data), 0);
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 9; c++) begin
        run_pair(c % 3, c / 3, DW'(r * 37 + c * 5 + 1), DW'(r * 53 + c * 11 + 2));
      end
    end
    // fixed corner sequence: owner supplies, then re-own, then peer read
    run_pair(2, 0, 8'hA5, 8'h00);
    run_pair(0, 1, 8'h00, 8'h00);
    run_pair(0, 2, 8'h00, 8'h3C);
    run_pair(1, 1, 8'h00, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule